// File: doc/BRIEF.md
# Predivider and Interval Timer

This block divides a base timing pulse through a chain of fifteen toggle stages and exposes every stage output as a tap. Stage k toggles whenever stage k-1 goes from high to low, so the tap vector behaves as a binary count of base pulses. A falling edge on stage 14 raises a sticky release flag that can wake a halted core or request an interrupt. Software can force the five upper stages low at any time.

A six-bit down-counting interval timer runs beside the chain. Its step clock is one of three taps or an external frequency-generator signal. The choice is made by a two-bit code that arrives with the six-bit preset in one configuration word. Every source is sampled as a level on the single system clock and edge-detected, so the block has one clock domain. The external frequency input must already be synchronous to that clock. When the count is zero and another source edge arrives, the timer reloads its preset and raises its own sticky release flag.

The configuration word arrives as a plain one-cycle write strobe. The strobes that clear the upper stages and each flag are also one cycle wide and plain. No input can be held off, so the block applies no back-pressure.

Top module: `predivider_timer`

## Requirements
- R1: `base_tick` high for one cycle advances the 15 taps as a binary count, `taps[k]` being stage k (stage 1 is the least significant). The taps hold their value when neither `base_tick` nor `div_clr` is high.
- R2: `div_clr` forces taps 11 to 15 low on the same clock edge. The lower ten stages still advance if `base_tick` is high in that cycle.
- R3: `pdv_flag` is set on the same clock edge on which tap 14 goes from high to low. This includes a transition caused by `div_clr`.
- R4: `cfg_wr` latches `cfg_word[5:0]` as the preset and `cfg_word[7:6]` as the source code. `tmr_count` equals the new preset one cycle later. A source edge in the write cycle is dropped.
- R5: Source codes are 2'b11 for `freq_in`, 2'b10 for tap 15, 2'b01 for tap 3 and 2'b00 for tap 9. The count decrements on the first clock edge at which the selected level is sampled low after being sampled high. A tap that falls at edge E therefore decrements the count at edge E+1.
- R6: A source edge that finds the count at zero reloads the preset and sets `tmr_flag` on the same edge.
- R7: Each flag stays set until its clear strobe is high. When a set and a clear fall in the same cycle, the set wins.
- R8: `rst_n` low (asynchronous) or `ext_rst` high (synchronous) clears the taps, the count, both flags and the preset, and sets the source code to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst | input | 1 | External reset, active high, synchronous |
| base_tick | input | 1 | One-cycle pulse per base period |
| freq_in | input | 1 | Frequency-generator level, synchronous to clk |
| div_clr | input | 1 | Force taps 11 to 15 low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_word | input | 8 | [7:6] source code, [5:0] preset |
| tmr_flag_clr | input | 1 | Clear the timer flag |
| pdv_flag_clr | input | 1 | Clear the predivider flag |
| taps | output | 15 | Stage outputs 1 to 15 |
| tmr_count | output | 6 | Current timer count |
| tmr_flag | output | 1 | Timer release flag |
| pdv_flag | output | 1 | Predivider release flag |

## Verification
Several events can land in the same cycle. A flag clear strobe can meet the event that sets that flag. `div_clr` can coincide with a base pulse or with tap 14 being high. A configuration write can coincide with a source edge. The bench raises the clear strobes and `div_clr` at random rates, and it holds the flag clear high for long windows so that it straddles flag events. It also writes configuration while tap 3 is toggling every few cycles. A behavioural model applies the rules above (set over clear, clear of the upper stages after the increment, write over step), and every output is compared against it on every clock.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic [1:0] {
    SRC_PH9  = 2'b00,
    SRC_PH3  = 2'b01,
    SRC_PH15 = 2'b10,
    SRC_FREQ = 2'b11
  } src_sel_e;
endpackage

// File: rtl/pdv_chain.sv
module pdv_chain #(
  parameter int STAGES    = 15,
  parameter int CLR_FROM  = 11,
  parameter int REL_STAGE = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst,
  input  logic              tick,
  input  logic              clr_hi,
  output logic [STAGES:1]   ph,
  output logic              rel_evt
);
  logic [STAGES:1] q, d, en;

  assign en[1] = tick;

  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    if (k < STAGES) begin : g_carry
      assign en[k+1] = en[k] & q[k];
    end
    if (k >= CLR_FROM) begin : g_clr
      assign d[k] = clr_hi ? 1'b0 : (q[k] ^ en[k]);
    end else begin : g_free
      assign d[k] = q[k] ^ en[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (ext_rst) q <= '0;
    else              q <= d;
  end

  assign ph      = q;
  assign rel_evt = q[REL_STAGE] & ~d[REL_STAGE] & ~ext_rst;
endmodule

// File: rtl/tap_edge.sv
module tap_edge
  import pdt_pkg::*;
#(
  parameter int STAGES  = 15,
  parameter int TAP_LO  = 3,
  parameter int TAP_MID = 9,
  parameter int TAP_HI  = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_rst,
  input  logic [STAGES:1] taps,
  input  logic            freq_in,
  input  src_sel_e        cur_sel,
  input  logic            load,
  input  src_sel_e        load_sel,
  output logic            fall
);
  function automatic logic pick(input src_sel_e s, input logic [STAGES:1] t, input logic f);
    case (s)
      SRC_FREQ: pick = f;
      SRC_PH15: pick = t[TAP_HI];
      SRC_PH3:  pick = t[TAP_LO];
      default:  pick = t[TAP_MID];
    endcase
  endfunction

  logic lvl_cur, lvl_new, prev_q;

  assign lvl_cur = pick(cur_sel, taps, freq_in);
  assign lvl_new = pick(load_sel, taps, freq_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= 1'b0;
    else if (ext_rst) prev_q <= 1'b0;
    else if (load)    prev_q <= lvl_new;
    else              prev_q <= lvl_cur;
  end

  assign fall = prev_q & ~lvl_cur;
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import pdt_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  src_sel_e     load_sel,
  input  logic         step,
  output src_sel_e     sel,
  output logic [W-1:0] count,
  output logic         uf_evt
);
  logic [W-1:0] preset_q, cnt_q;
  src_sel_e     sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= '0;
      cnt_q    <= '0;
      sel_q    <= SRC_PH9;
    end else if (ext_rst) begin
      preset_q <= '0;
      cnt_q    <= '0;
      sel_q    <= SRC_PH9;
    end else if (load) begin
      preset_q <= load_val;
      cnt_q    <= load_val;
      sel_q    <= load_sel;
    end else if (step) begin
      cnt_q <= (cnt_q == '0) ? preset_q : cnt_q - 1'b1;
    end
  end

  assign sel    = sel_q;
  assign count  = cnt_q;
  assign uf_evt = step & ~load & (cnt_q == '0);
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (ext_rst) q <= 1'b0;
    else              q <= set | (q & ~clr);
  end
endmodule

// File: rtl/predivider_timer.sv
module predivider_timer
  import pdt_pkg::*;
#(
  parameter int STAGES    = 15,
  parameter int CLR_FROM  = 11,
  parameter int REL_STAGE = 14,
  parameter int TMR_W     = 6,
  parameter int TAP_LO    = 3,
  parameter int TAP_MID   = 9,
  parameter int TAP_HI    = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_rst,
  input  logic                 base_tick,
  input  logic                 freq_in,
  input  logic                 div_clr,
  input  logic                 cfg_wr,
  input  logic [TMR_W+1:0]     cfg_word,
  input  logic                 tmr_flag_clr,
  input  logic                 pdv_flag_clr,
  output logic [STAGES:1]      taps,
  output logic [TMR_W-1:0]     tmr_count,
  output logic                 tmr_flag,
  output logic                 pdv_flag
);
  localparam int SEL_LSB = TMR_W;

  logic     pdv_evt, src_fall, uf_evt;
  src_sel_e cur_sel, new_sel;

  assign new_sel = src_sel_e'(cfg_word[SEL_LSB+1:SEL_LSB]);

  pdv_chain #(.STAGES(STAGES), .CLR_FROM(CLR_FROM), .REL_STAGE(REL_STAGE)) u_chain (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .tick(base_tick),
    .clr_hi(div_clr), .ph(taps), .rel_evt(pdv_evt)
  );

  tap_edge #(.STAGES(STAGES), .TAP_LO(TAP_LO), .TAP_MID(TAP_MID), .TAP_HI(TAP_HI)) u_edge (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .taps(taps), .freq_in(freq_in),
    .cur_sel(cur_sel), .load(cfg_wr), .load_sel(new_sel), .fall(src_fall)
  );

  ivl_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .load(cfg_wr),
    .load_val(cfg_word[TMR_W-1:0]), .load_sel(new_sel), .step(src_fall),
    .sel(cur_sel), .count(tmr_count), .uf_evt(uf_evt)
  );

  sticky_flag u_tflag (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst),
    .set(uf_evt), .clr(tmr_flag_clr), .q(tmr_flag)
  );

  sticky_flag u_pflag (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst),
    .set(pdv_evt), .clr(pdv_flag_clr), .q(pdv_flag)
  );
endmodule

// File: rtl/pdt_checker.sv
module pdt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ext_rst,
  input logic        base_tick,
  input logic        div_clr,
  input logic        cfg_wr,
  input logic [7:0]  cfg_word,
  input logic        tmr_flag_clr,
  input logic        pdv_flag_clr,
  input logic [15:1] taps,
  input logic [5:0]  tmr_count,
  input logic        tmr_flag,
  input logic        pdv_flag
);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n || ext_rst)
    (!base_tick && !div_clr) |=> $stable(taps));

  assert_upper_clear_R2: assert property (@(posedge clk) disable iff (!rst_n || ext_rst)
    div_clr |=> (taps[15:11] == 5'd0));

  assert_pdv_set_R3: assert property (@(posedge clk) disable iff (!rst_n || ext_rst)
    ($fell(taps[14]) && $past(rst_n && !ext_rst)) |-> pdv_flag);

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n || ext_rst)
    cfg_wr |=> (tmr_count == $past(cfg_word[5:0])));

  assert_tflag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n || ext_rst)
    (tmr_flag && !tmr_flag_clr) |=> tmr_flag);

  assert_pflag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n || ext_rst)
    (pdv_flag && !pdv_flag_clr) |=> pdv_flag);

  assert_ext_reset_R8: assert property (@(posedge clk)
    (rst_n && ext_rst) |=> (taps == 15'd0 && tmr_count == 6'd0 && !tmr_flag && !pdv_flag));
endmodule

bind predivider_timer pdt_checker u_chk (.*);

// File: tb/sim_predivider_timer.sv
module sim_predivider_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_rst = 1'b0;
  logic        base_tick = 1'b0;
  logic        freq_in = 1'b0;
  logic        div_clr = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_word = 8'd0;
  logic        tmr_flag_clr = 1'b0;
  logic        pdv_flag_clr = 1'b0;
  logic [15:1] taps;
  logic [5:0]  tmr_count;
  logic        tmr_flag;
  logic        pdv_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit armed = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  predivider_timer u0 (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .base_tick(base_tick),
    .freq_in(freq_in), .div_clr(div_clr), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .tmr_flag_clr(tmr_flag_clr), .pdv_flag_clr(pdv_flag_clr), .taps(taps),
    .tmr_count(tmr_count), .tmr_flag(tmr_flag), .pdv_flag(pdv_flag)
  );

  // behavioural reference
  logic [14:0] m_cnt = 15'd0;
  int m_preset = 0, m_src = 0, m_count = 0;
  bit m_prev = 0, m_tflag = 0, m_pflag = 0;

  function automatic bit src_level(int s, logic [14:0] c, bit f);
    if (s == 3) return f;
    if (s == 2) return c[14];
    if (s == 1) return c[2];
    return c[8];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || ext_rst) begin
      m_cnt = 0; m_preset = 0; m_src = 0; m_count = 0;
      m_prev = 0; m_tflag = 0; m_pflag = 0;
    end else begin
      logic [14:0] nxt;
      bit pfall, lvl, tev;
      nxt = base_tick ? m_cnt + 15'd1 : m_cnt;
      if (div_clr) nxt = nxt & 15'h03FF;
      pfall = m_cnt[13] && !nxt[13];
      tev = 0;
      lvl = src_level(m_src, m_cnt, freq_in);
      if (cfg_wr) begin
        m_src = int'(cfg_word[7:6]);
        m_preset = int'(cfg_word[5:0]);
        m_count = m_preset;
        m_prev = src_level(m_src, m_cnt, freq_in);
      end else begin
        if (m_prev && !lvl) begin
          if (m_count == 0) begin m_count = m_preset; tev = 1; end
          else m_count = m_count - 1;
        end
        m_prev = lvl;
      end
      m_tflag = tev || (m_tflag && !tmr_flag_clr);
      m_pflag = pfall || (m_pflag && !pdv_flag_clr);
      m_cnt = nxt;
    end
    if (rst_n) armed = 1'b1;
  end

  always @(negedge clk) begin
    cyc++;
    if (armed && !done) begin
      checks++;
      if (taps !== m_cnt) begin errors++; $display("FAIL R1/R2 taps got %h exp %h", taps, m_cnt); end
      checks++;
      if (pdv_flag !== m_pflag) begin errors++; $display("FAIL R3/R7 pdv_flag got %b exp %b", pdv_flag, m_pflag); end
      checks++;
      if (tmr_count !== 6'(m_count)) begin errors++; $display("FAIL R4/R5/R6 tmr_count got %0d exp %0d", tmr_count, m_count); end
      checks++;
      if (tmr_flag !== m_tflag) begin errors++; $display("FAIL R6/R7 tmr_flag got %b exp %b", tmr_flag, m_tflag); end
    end
    if (cyc >= 190000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog got cycle %0d exp below 190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic write_cfg(input logic [1:0] s, input logic [5:0] p);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_word = {s, p};
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run(input int n, input int tick_pct, input int dclr_pct,
                     input int fclr_pct, input int frq_pct, input int wr_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      base_tick    = ($urandom_range(99) < tick_pct);
      div_clr      = ($urandom_range(999) < dclr_pct);
      tmr_flag_clr = ($urandom_range(99) < fclr_pct);
      pdv_flag_clr = ($urandom_range(99) < fclr_pct);
      if ($urandom_range(99) < frq_pct) freq_in = ~freq_in;
      cfg_wr   = ($urandom_range(999) < wr_pct);
      cfg_word = 8'($urandom);
    end
    @(negedge clk);
    base_tick = 0; div_clr = 0; tmr_flag_clr = 0; pdv_flag_clr = 0; cfg_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: state under power-on reset
    checks++;
    if (taps !== 15'd0 || tmr_count !== 6'd0 || tmr_flag !== 1'b0 || pdv_flag !== 1'b0) begin
      errors++; $display("FAIL R8 reset state got %h/%0d/%b/%b exp 0/0/0/0", taps, tmr_count, tmr_flag, pdv_flag);
    end
    rst_n = 1'b1;
    // R5 tap 3 source, R4 write over step, R6 reload
    write_cfg(2'b01, 6'd5);
    run(3000, 100, 0, 5, 0, 20);
    // R5 external source, preset zero flags every edge
    write_cfg(2'b11, 6'd0);
    run(2000, 50, 0, 30, 40, 0);
    // R2 upper clear against running chain, tap 9 source
    write_cfg(2'b00, 6'd40);
    run(20000, 100, 2, 2, 0, 0);
    // R3 R7: long clear window straddling tap 14 falls
    write_cfg(2'b10, 6'd1);
    @(negedge clk); pdv_flag_clr = 1'b1; tmr_flag_clr = 1'b1; base_tick = 1'b1;
    repeat (20000) @(negedge clk);
    pdv_flag_clr = 1'b0; tmr_flag_clr = 1'b0;
    run(50000, 100, 0, 1, 0, 0);
    // R2 directed: clear upper stages with a tick in the same cycle
    @(negedge clk); div_clr = 1'b1; base_tick = 1'b1;
    @(negedge clk); div_clr = 1'b0; base_tick = 1'b0;
    checks++;
    if (taps[15:11] !== 5'd0) begin errors++; $display("FAIL R2 upper taps got %h exp 0", taps[15:11]); end
    // R8: synchronous external reset mid-run
    run(500, 100, 0, 0, 0, 0);
    @(negedge clk); ext_rst = 1'b1;
    @(negedge clk); ext_rst = 1'b0;
    checks++;
    if (taps !== 15'd0 || tmr_count !== 6'd0) begin
      errors++; $display("FAIL R8 ext reset got %h/%0d exp 0/0", taps, tmr_count);
    end
    run(3000, 80, 3, 10, 20, 10);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule